// File: doc/BRIEF.md
# Lockable Memory-Mapped GPIO Controller

An eight-pin general-purpose I/O peripheral sitting on a simple 32-bit register bus with a 4 KB window. Software sets each pin's direction, reads and writes pin values through a data window whose address bits act as a per-bit mask, and configures per-pin interrupt detection (edge or level, with polarity and an any-edge option) that is merged into one interrupt line.

Alternate-function selection is guarded twice: a commit mask decides which select bits may change, and the commit mask itself can only be rewritten after a magic key has been written to the lock register. Eight pad-control bytes are kept for software but drive nothing, and the top of the window returns fixed identification bytes. External pin levels pass through a synchronizer before they feed the data register and the interrupt detectors.

Top module: `gpio_lockable`

## Requirements
- R1: A read at a word offset below 0x400 returns the data register ANDed with address bits [9:2]; the upper 24 read bits are zero.
- R2: A write at an offset below 0x400 changes only data bits whose mask bit (address bits [9:2]) is 1 and whose direction bit is 1.
- R3: The direction register sits at 0x400 (1 = output); the pin output vector drives data on output pins and 1 on input pins.
- R4: On input pins the data register takes the synchronized pin level three clock edges after the pin changes; on output pins the pin input has no effect.
- R5: The lock register at 0x520 reads 1 after reset; writing 0x0ACCE551 makes it read 0, any other written value makes it read 1.
- R6: The commit register at 0x524 resets to 0xFF and accepts writes only while the lock reads 0.
- R7: A write to the alternate-function register at 0x420 changes only the bits set in the commit register.
- R8: Offsets 0x500, 0x504 … 0x51C hold eight independent read/write bytes with no effect on pins.
- R9: Word offsets 0xFD0 to 0xFFC read, in ascending address order, 00 00 00 00 61 00 18 01 0D F0 05 B1.
- R10: With sense bit 0 (register 0x404), a pin's raw status bit (0x414) sets on any edge if its both-edges bit (0x408) is 1, otherwise on a rising edge if its event bit (0x40C) is 1 and on a falling edge if it is 0.
- R11: With sense bit 1, the raw status bit is set every cycle the synchronized level equals the event bit, so a clear during a matching level does not stick.
- R12: Writing 1s to 0x41C clears raw bits; 0x418 reads raw AND mask (mask at 0x410); the interrupt output is 1 exactly when any masked bit is 1.
- R13: Undefined offsets read zero and ignore writes; data, direction, interrupt configuration and raw status reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| pin_in | input | 8 | External pin levels |
| pin_out | output | 8 | Pin output vector |
| irq | output | 1 | Combined interrupt |

## Verification
The data window is driven with full, low-nibble and high-nibble address masks and with mixed direction settings, which separates the address mask from the direction gate and shows input pins tracking the pins while output pins hold. Interrupts are tried with a rising-only pin, a falling-only pin and a both-edges pin toggled together, so a wrong polarity or a missing both-edges path shows up as a wrong raw pattern. Level sense is tried at both polarities with a clear while the level persists, and the lock is exercised with the key, a wrong key and commit writes on each side of it.

// File: rtl/gpio_lockable_pkg.sv
`timescale 1ns/1ps
package gpio_lockable_pkg;
   // word indices (byte offset >> 2)
   localparam logic [9:0] WI_DIR    = 10'h100;
   localparam logic [9:0] WI_SENSE  = 10'h101;
   localparam logic [9:0] WI_BOTH   = 10'h102;
   localparam logic [9:0] WI_EVT    = 10'h103;
   localparam logic [9:0] WI_MASK   = 10'h104;
   localparam logic [9:0] WI_RAW    = 10'h105;
   localparam logic [9:0] WI_MIS    = 10'h106;
   localparam logic [9:0] WI_CLR    = 10'h107;
   localparam logic [9:0] WI_ALT    = 10'h108;
   localparam logic [9:0] WI_PAD0   = 10'h140;
   localparam logic [9:0] WI_LOCK   = 10'h148;
   localparam logic [9:0] WI_COMMIT = 10'h149;
   localparam logic [9:0] WI_ID0    = 10'h3F4;
   localparam int         PAD_REGS  = 8;
   localparam logic [31:0] UNLOCK_KEY = 32'h0ACC_E551;

   function automatic logic [7:0] ident_byte(input logic [3:0] k);
      case (k)
         4'd4:    ident_byte = 8'h61;
         4'd6:    ident_byte = 8'h18;
         4'd7:    ident_byte = 8'h01;
         4'd8:    ident_byte = 8'h0D;
         4'd9:    ident_byte = 8'hF0;
         4'd10:   ident_byte = 8'h05;
         4'd11:   ident_byte = 8'hB1;
         default: ident_byte = 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync needs at least two stages");
   end

   logic [WIDTH-1:0] stage [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) stage[s] <= '0;
         else if (s == 0) stage[s] <= d;
         else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic sense_lvl,
   input  logic any_edge,
   input  logic polarity,
   input  logic clr,
   output logic raw
);
   logic prev_q;
   logic hit;

   always_comb begin
      if (sense_lvl)     hit = (lvl == polarity);
      else if (any_edge) hit = lvl ^ prev_q;
      else if (polarity) hit = lvl & ~prev_q;
      else               hit = ~lvl & prev_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         raw    <= 1'b0;
      end else begin
         prev_q <= lvl;
         raw    <= hit | (raw & ~clr);
      end
   end
endmodule

// File: rtl/gpio_lockable.sv
`timescale 1ns/1ps
module gpio_lockable
   import gpio_lockable_pkg::*;
#(
   parameter int NPINS       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic              irq
);
   localparam int WIDX_W = ADDR_W - 2;

   if (NPINS != 8) begin : g_bad_pins
      $error("address-mask data window requires NPINS == 8");
   end
   if (ADDR_W != 12) begin : g_bad_addr
      $error("register window is 4 KB: ADDR_W must be 12");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("lock key compare requires DATA_W == 32");
   end

   logic [WIDX_W-1:0] widx;
   logic              wr_en;
   logic              in_data_win;
   logic [NPINS-1:0]  amask;
   logic [NPINS-1:0]  wbyte;
   logic              unused_lsb;

   assign widx        = bus_addr[ADDR_W-1:2];
   assign wr_en       = bus_sel & bus_wr;
   assign in_data_win = (widx[WIDX_W-1:WIDX_W-2] == 2'b00);
   assign amask       = bus_addr[NPINS+1:2];
   assign wbyte       = bus_wdata[NPINS-1:0];
   assign unused_lsb  = ^bus_addr[1:0];

   logic [NPINS-1:0] data_q, dir_q, sense_q, both_q, evt_q, im_q;
   logic [NPINS-1:0] alt_q, commit_q, raw;
   logic             locked_q;
   logic [NPINS-1:0] pad_q [PAD_REGS];

   // synchronized pin levels
   logic [NPINS-1:0] lvl;
   gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl)
   );

   // data register: outputs keep or take bus data, inputs follow pins
   logic [NPINS-1:0] wsel, data_nxt;
   always_comb begin
      wsel     = (wr_en && in_data_win) ? (amask & dir_q) : '0;
      data_nxt = (data_q & dir_q & ~wsel) | (wbyte & wsel) | (lvl & ~dir_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q   <= '0;
         dir_q    <= '0;
         sense_q  <= '0;
         both_q   <= '0;
         evt_q    <= '0;
         im_q     <= '0;
         alt_q    <= '0;
         commit_q <= '1;
         locked_q <= 1'b1;
      end else begin
         data_q <= data_nxt;
         if (wr_en) begin
            case (widx)
               WI_DIR:    dir_q    <= wbyte;
               WI_SENSE:  sense_q  <= wbyte;
               WI_BOTH:   both_q   <= wbyte;
               WI_EVT:    evt_q    <= wbyte;
               WI_MASK:   im_q     <= wbyte;
               WI_ALT:    alt_q    <= (alt_q & ~commit_q) | (wbyte & commit_q);
               WI_LOCK:   locked_q <= (bus_wdata != UNLOCK_KEY);
               WI_COMMIT: if (!locked_q) commit_q <= wbyte;
               default: ;
            endcase
         end
      end
   end

   // pad-control storage
   for (genvar p = 0; p < PAD_REGS; p++) begin : g_pad
      localparam logic [WIDX_W-1:0] PAD_IDX = WI_PAD0 + WIDX_W'(p);
      always_ff @(posedge clk) begin
         if (!rst_n) pad_q[p] <= '0;
         else if (wr_en && widx == PAD_IDX) pad_q[p] <= wbyte;
      end
   end

   // per-pin interrupt detection
   logic [NPINS-1:0] clr_vec;
   assign clr_vec = (wr_en && widx == WI_CLR) ? wbyte : '0;

   for (genvar i = 0; i < NPINS; i++) begin : g_irq
      gpio_irq_detect u_det (
         .clk(clk), .rst_n(rst_n), .lvl(lvl[i]),
         .sense_lvl(sense_q[i]), .any_edge(both_q[i]), .polarity(evt_q[i]),
         .clr(clr_vec[i]), .raw(raw[i])
      );
   end

   assign irq     = |(raw & im_q);
   assign pin_out = (data_q & dir_q) | ~dir_q;

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (in_data_win) begin
         bus_rdata[NPINS-1:0] = data_q & amask;
      end else if (widx >= WI_ID0) begin
         bus_rdata[7:0] = ident_byte(4'(widx - WI_ID0));
      end else if (widx[WIDX_W-1:3] == WI_PAD0[WIDX_W-1:3]) begin
         bus_rdata[NPINS-1:0] = pad_q[widx[2:0]];
      end else begin
         case (widx)
            WI_DIR:    bus_rdata[NPINS-1:0] = dir_q;
            WI_SENSE:  bus_rdata[NPINS-1:0] = sense_q;
            WI_BOTH:   bus_rdata[NPINS-1:0] = both_q;
            WI_EVT:    bus_rdata[NPINS-1:0] = evt_q;
            WI_MASK:   bus_rdata[NPINS-1:0] = im_q;
            WI_RAW:    bus_rdata[NPINS-1:0] = raw;
            WI_MIS:    bus_rdata[NPINS-1:0] = raw & im_q;
            WI_ALT:    bus_rdata[NPINS-1:0] = alt_q;
            WI_LOCK:   bus_rdata[0]         = locked_q;
            WI_COMMIT: bus_rdata[NPINS-1:0] = commit_q;
            default:   bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/gpio_lockable_chk.sv
`timescale 1ns/1ps
module gpio_lockable_chk #(
   parameter int NPINS = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_sel,
   input logic             bus_wr,
   input logic             irq,
   input logic [NPINS-1:0] pin_out,
   input logic [NPINS-1:0] data_q,
   input logic [NPINS-1:0] dir_q,
   input logic [NPINS-1:0] im_q,
   input logic [NPINS-1:0] commit_q,
   input logic [NPINS-1:0] alt_q,
   input logic             locked_q
);
   // input pins are driven high on the output vector
   assert_input_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((~dir_q) & ~pin_out) == '0);

   // without a bus write, output-pin data bits hold
   assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_wr) |=> ((data_q ^ $past(data_q)) & $past(dir_q)) == '0);

   // commit mask frozen while locked
   assert_commit_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |=> $stable(commit_q));

   // alternate-function bits outside the commit mask never move
   assert_alt_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((alt_q ^ $past(alt_q)) & ~$past(commit_q)) == '0);

   // no interrupt while every mask bit is clear
   assert_irq_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (im_q == '0) |-> !irq);
endmodule

bind gpio_lockable gpio_lockable_chk #(.NPINS(NPINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .irq(irq),
   .pin_out(pin_out), .data_q(data_q), .dir_q(dir_q), .im_q(im_q),
   .commit_q(commit_q), .alt_q(alt_q), .locked_q(locked_q)
);

// File: tb/gpio_lockable_test.sv
`timescale 1ns/1ps
module gpio_lockable_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  pin_in = '0;
   logic [7:0]  pin_out;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   gpio_lockable uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      rd_check("R13 dir reset", 12'h400, 32'h0);
      rd_check("R13 sense reset", 12'h404, 32'h0);
      rd_check("R13 raw reset", 12'h414, 32'h0);
      rd_check("R5 lock after reset", 12'h520, 32'h1);
      rd_check("R6 commit reset", 12'h524, 32'hFF);
      check("R3 all inputs drive high", {24'h0, pin_out}, 32'hFF);
      check("R12 irq reset", {31'h0, irq}, 32'h0);
   endtask

   task automatic t_data();
      wr(12'h400, 32'hFF);
      wr(12'h3FC, 32'hFFFF_FFA5);
      rd_check("R1 full mask read", 12'h3FC, 32'hA5);
      rd_check("R1 low nibble mask read", 12'h03C, 32'h05);
      wr(12'h3C0, 32'h00);
      rd_check("R2 high-nibble write", 12'h3FC, 32'h05);
      check("R3 outputs drive data", {24'h0, pin_out}, 32'h05);
      wr(12'h400, 32'h0F);
      wr(12'h3FC, 32'hFF);
      rd_check("R2 direction gates write", 12'h3FC, 32'h0F);
      check("R3 mixed direction", {24'h0, pin_out}, 32'hFF);
   endtask

   task automatic t_input();
      pin_in = 8'hA3;
      settle(4);
      rd_check("R4 inputs tracked, outputs hold", 12'h3FC, 32'hAF);
      pin_in = 8'h00;
      settle(4);
      rd_check("R4 inputs follow low", 12'h3FC, 32'h0F);
   endtask

   task automatic t_lock();
      wr(12'h524, 32'h00);
      rd_check("R6 commit ignored while locked", 12'h524, 32'hFF);
      wr(12'h520, 32'h0ACC_E551);
      rd_check("R5 key unlocks", 12'h520, 32'h0);
      wr(12'h524, 32'h0F);
      rd_check("R6 commit written unlocked", 12'h524, 32'h0F);
      wr(12'h520, 32'h1234);
      rd_check("R5 wrong key relocks", 12'h520, 32'h1);
      wr(12'h524, 32'h00);
      rd_check("R6 commit held after relock", 12'h524, 32'h0F);
      wr(12'h420, 32'hFF);
      rd_check("R7 only committed bits set", 12'h420, 32'h0F);
      wr(12'h520, 32'h0ACC_E551);
      wr(12'h524, 32'hF0);
      wr(12'h420, 32'h00);
      rd_check("R7 uncommitted bits kept", 12'h420, 32'h0F);
      wr(12'h420, 32'hFF);
      rd_check("R7 high bits now committed", 12'h420, 32'hFF);
   endtask

   task automatic t_pad();
      for (int i = 0; i < 8; i++) wr(12'h500 + 12'(4*i), 32'(8'h11 * (i + 1) + 3));
      for (int i = 0; i < 8; i++)
         rd_check("R8 pad byte readback", 12'h500 + 12'(4*i), 32'(8'(8'h11 * (i + 1) + 3)));
      check("R8 pads leave pins", {24'h0, pin_out}, 32'hFF);
   endtask

   task automatic t_ident();
      logic [7:0] exp_id [12] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h61, 8'h00,
                                  8'h18, 8'h01, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      for (int i = 0; i < 12; i++)
         rd_check("R9 ident byte", 12'hFD0 + 12'(4*i), {24'h0, exp_id[i]});
   endtask

   task automatic t_undef();
      wr(12'h600, 32'hFF);
      rd_check("R13 undefined reads zero", 12'h600, 32'h0);
      rd_check("R13 clear reg reads zero", 12'h41C, 32'h0);
      wr(12'h41C + 12'h20, 32'hFF);
      rd_check("R13 undefined write leaves dir", 12'h400, 32'h0F);
   endtask

   task automatic t_edge();
      wr(12'h400, 32'h00);
      wr(12'h404, 32'h00);
      wr(12'h408, 32'h04);
      wr(12'h40C, 32'h01);
      wr(12'h410, 32'hFF);
      settle(4);
      wr(12'h41C, 32'hFF);
      rd_check("R10 raw clear baseline", 12'h414, 32'h00);
      pin_in = 8'h07;
      settle(4);
      rd_check("R10 rising and any-edge", 12'h414, 32'h05);
      check("R12 irq on edge", {31'h0, irq}, 32'h1);
      wr(12'h41C, 32'hFF);
      pin_in = 8'h00;
      settle(4);
      rd_check("R10 falling and any-edge", 12'h414, 32'h06);
      wr(12'h41C, 32'hFF);
      rd_check("R12 write-one clears", 12'h414, 32'h00);
      check("R12 irq drops after clear", {31'h0, irq}, 32'h0);
   endtask

   task automatic t_level();
      wr(12'h408, 32'h00);
      wr(12'h404, 32'h30);
      wr(12'h40C, 32'h11);
      wr(12'h410, 32'h10);
      settle(4);
      wr(12'h41C, 32'hFF);
      rd_check("R11 low level persists", 12'h414, 32'h20);
      check("R12 unmasked level no irq", {31'h0, irq}, 32'h0);
      pin_in = 8'h30;
      settle(4);
      wr(12'h41C, 32'hFF);
      rd_check("R11 high level survives clear", 12'h414, 32'h10);
      rd_check("R12 masked status", 12'h418, 32'h10);
      check("R12 irq on masked level", {31'h0, irq}, 32'h1);
      wr(12'h410, 32'h00);
      rd_check("R12 masked status cleared by mask", 12'h418, 32'h00);
      check("R12 irq gated by mask", {31'h0, irq}, 32'h0);
      pin_in = 8'h00;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_data();
      t_input();
      t_lock();
      t_pad();
      t_ident();
      t_undef();
      t_edge();
      t_level();
      settle(2);
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule